// File: doc/BRIEF.md
# Burst Register Command Engine

This block takes register-access commands as a stream of 32-bit words and carries them out against a word-addressed register space. Each command opens with one header word that names an operation, a start address and a word count. The block then performs a burst read, a burst overwrite, or a burst read-modify-write over that many consecutive addresses. The read-modify-write merges each stored value with a supplied word using OR, AND or XOR. Replies go out on a second 32-bit word stream. Both streams use valid/ready handshakes.

The block drives a simple synchronous register bus internally. That bus serves a small register array of `NUM_REGS` words, so the engine can be exercised with no surrounding logic. Every reply begins with one status word. A malformed command gets that status word and nothing else, and no register is changed.

Top module: `regcmd_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, and every register in the array holds zero.
- R2: Header word layout: bits [31:28] are the operation code (0 read, 1 write, 2 merge with OR, 3 merge with AND, 4 merge with XOR). Bits [27:12] are the start address. Bits [11:0] are the count N.
- R3: A read command replies with a status word, then N words. These are the contents of addresses start, start+1, … start+N-1, in that order.
- R4: A write command replies with its status word first. It then accepts N payload words and stores the k-th one at address start+k.
- R5: A merge command (codes 2, 3, 4) handles N words in turn. For each word it accepts one payload word, reads the stored word at start+k, and writes back stored OR/AND/XOR payload. It then returns the written value. The write of one word completes before the read of the next word starts.
- R6: A header is rejected if its code is 5 to 15 (error 1), else if N is 0 (error 2), else if start+N exceeds `NUM_REGS` (error 3). A rejected header produces only a status word and changes no register. The next input word is taken as a fresh header.
- R7: Status word layout: bits [31:28] echo the operation code. Bits [27:24] hold the error code (0 when accepted). Bits [23:12] are zero. Bits [11:0] echo N.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` does not change. Under any stall pattern, no reply word is lost or repeated.
- R9: The block never raises `cmd_ready` and `rsp_valid` in the same cycle.
- R10: A synchronous reset asserted in the middle of a command abandons that command. The block returns to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word accepted this cycle when valid |
| cmd_data | input | 32 | Command word (header or payload) |
| rsp_valid | output | 1 | Reply word offered |
| rsp_ready | input | 1 | Consumer takes reply word |
| rsp_data | output | 32 | Reply word (status or data) |

## Verification
The bench runs every operation over every legal start address and length of a 16-word array. It checks against a model, so an address that fails to advance, or a wrong merge operator, shows up as a wrong word. Bursts that end exactly on the last word are checked next to starts and lengths that overrun by one, and against an address field large enough to wrap. An off-by-one range test would either reject a legal burst or corrupt nothing visible yet return a status with a zero error code. Replies are stalled for varying lengths, so a design that dropped or re-sent a word under backpressure would shift every following comparison. A reset in the middle of a write checks that the partial burst is abandoned and the array cleared.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

    localparam int WORD_W = 32;
    localparam int OP_W   = 4;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 12;
    localparam int CODE_W = 4;
    localparam int PAD_W  = WORD_W - OP_W - CODE_W - CNT_W;

    typedef enum logic [OP_W-1:0] {
        OP_READ    = 4'd0,
        OP_WRITE   = 4'd1,
        OP_RMW_OR  = 4'd2,
        OP_RMW_AND = 4'd3,
        OP_RMW_XOR = 4'd4
    } op_e;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE   = 4'd0,
        ERR_OPCODE = 4'd1,
        ERR_COUNT  = 4'd2,
        ERR_RANGE  = 4'd3
    } err_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } hdr_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [CODE_W-1:0] code;
        logic [PAD_W-1:0]  pad;
        logic [CNT_W-1:0]  cnt;
    } status_t;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    function automatic logic is_merge(input logic [OP_W-1:0] op);
        return (op == OP_RMW_OR) || (op == OP_RMW_AND) || (op == OP_RMW_XOR);
    endfunction

    function automatic logic [WORD_W-1:0] merge_word(input logic [OP_W-1:0] op,
                                                     input logic [WORD_W-1:0] stored,
                                                     input logic [WORD_W-1:0] pay);
        logic [WORD_W-1:0] res;
        case (op)
            OP_RMW_OR:  res = stored | pay;
            OP_RMW_AND: res = stored & pay;
            OP_RMW_XOR: res = stored ^ pay;
            default:    res = stored;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/regcmd_hdr_check.sv
module regcmd_hdr_check
    import regcmd_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic [WORD_W-1:0] word,
    output err_e              code
);
    localparam int SUM_W = ADDR_W + 1;

    hdr_t             hdr;
    logic [SUM_W-1:0] end_excl;
    logic             op_ok;

    assign hdr      = hdr_t'(word);
    assign end_excl = {1'b0, hdr.addr} + SUM_W'(hdr.cnt);
    assign op_ok    = (hdr.op <= OP_W'(OP_RMW_XOR));

    always_comb begin
        if (!op_ok)
            code = ERR_OPCODE;
        else if (hdr.cnt == '0)
            code = ERR_COUNT;
        else if (end_excl > SUM_W'(NUM_REGS))
            code = ERR_RANGE;
        else
            code = ERR_NONE;
    end
endmodule

// File: rtl/regcmd_regfile.sv
module regcmd_regfile
    import regcmd_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] regs [NUM_REGS];
    logic [WORD_W-1:0] rd_sel;
    logic [NUM_REGS-1:0] hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign hit[g] = (req.addr == ADDR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (req.en && req.we && hit[i])
                regs[i] <= req.wdata;
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (hit[i]) rd_sel = regs[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (req.en && !req.we)
            rdata <= rd_sel;
    end

    // R6: rejected ranges never reach the array
    p_addr_inside_r6: assert property (@(posedge clk) disable iff (rst)
        req.en |-> (req.addr < ADDR_W'(NUM_REGS)));

    // R1: a reset clears the read port
    p_rdata_cleared_r1: assert property (@(posedge clk)
        rst |=> (rdata == '0));
endmodule

// File: rtl/regcmd_seq.sv
module regcmd_seq
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_data,
    input  err_e              hdr_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data,
    output bus_req_t          bus_req,
    input  logic [WORD_W-1:0] bus_rdata
);
    typedef enum logic [3:0] {
        S_IDLE, S_STATUS,
        S_RD_REQ, S_RD_CAP, S_RD_OUT,
        S_WR_IN,
        S_MG_IN, S_MG_RD, S_MG_WR, S_MG_OUT
    } state_e;

    state_e            state;
    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic              rej_q;
    logic [WORD_W-1:0] out_q;
    logic [WORD_W-1:0] pay_q;
    logic [WORD_W-1:0] merged;
    logic              last_word;
    hdr_t              hdr;
    status_t           stat;

    assign hdr       = hdr_t'(cmd_data);
    assign merged    = merge_word(op_q, bus_rdata, pay_q);
    assign last_word = (left_q == CNT_W'(1));

    always_comb begin
        stat.op   = hdr.op;
        stat.code = hdr_err;
        stat.pad  = '0;
        stat.cnt  = hdr.cnt;
    end

    assign cmd_ready = (state == S_IDLE) || (state == S_WR_IN) || (state == S_MG_IN);
    assign rsp_valid = (state == S_STATUS) || (state == S_RD_OUT) || (state == S_MG_OUT);
    assign rsp_data  = out_q;

    always_comb begin
        bus_req = '0;
        case (state)
            S_RD_REQ, S_MG_RD: begin
                bus_req.en   = 1'b1;
                bus_req.addr = addr_q;
            end
            S_WR_IN: begin
                bus_req.en    = cmd_valid;
                bus_req.we    = 1'b1;
                bus_req.addr  = addr_q;
                bus_req.wdata = cmd_data;
            end
            S_MG_WR: begin
                bus_req.en    = 1'b1;
                bus_req.we    = 1'b1;
                bus_req.addr  = addr_q;
                bus_req.wdata = merged;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            op_q   <= '0;
            addr_q <= '0;
            left_q <= '0;
            rej_q  <= 1'b0;
            out_q  <= '0;
            pay_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (cmd_valid) begin
                    op_q   <= hdr.op;
                    addr_q <= hdr.addr;
                    left_q <= hdr.cnt;
                    rej_q  <= (hdr_err != ERR_NONE);
                    out_q  <= stat;
                    state  <= S_STATUS;
                end
                S_STATUS: if (rsp_ready) begin
                    if (rej_q)
                        state <= S_IDLE;
                    else if (op_q == OP_READ)
                        state <= S_RD_REQ;
                    else if (op_q == OP_WRITE)
                        state <= S_WR_IN;
                    else
                        state <= S_MG_IN;
                end
                S_RD_REQ: state <= S_RD_CAP;
                S_RD_CAP: begin
                    out_q <= bus_rdata;
                    state <= S_RD_OUT;
                end
                S_RD_OUT: if (rsp_ready) begin
                    addr_q <= addr_q + 1'b1;
                    left_q <= left_q - 1'b1;
                    state  <= last_word ? S_IDLE : S_RD_REQ;
                end
                S_WR_IN: if (cmd_valid) begin
                    addr_q <= addr_q + 1'b1;
                    left_q <= left_q - 1'b1;
                    if (last_word) state <= S_IDLE;
                end
                S_MG_IN: if (cmd_valid) begin
                    pay_q <= cmd_data;
                    state <= S_MG_RD;
                end
                S_MG_RD: state <= S_MG_WR;
                S_MG_WR: begin
                    out_q <= merged;
                    state <= S_MG_OUT;
                end
                S_MG_OUT: if (rsp_ready) begin
                    addr_q <= addr_q + 1'b1;
                    left_q <= left_q - 1'b1;
                    state  <= last_word ? S_IDLE : S_MG_IN;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: a stalled reply word is held unchanged
    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R9: input and output never open together
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        !(cmd_ready && rsp_valid));

    // R5: every merge write follows a read of the same address
    p_merge_read_first_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req.en && bus_req.we && is_merge(op_q)) |->
            ($past(bus_req.en && !bus_req.we) && ($past(bus_req.addr) == bus_req.addr)));

    // R6: a rejected header causes no bus activity
    p_reject_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && cmd_valid && hdr_err != ERR_NONE) |=>
            (!bus_req.en ##1 !bus_req.en));

    // R4: a plain write only moves when a payload word is taken
    p_write_takes_word_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req.en && bus_req.we && op_q == OP_WRITE) |-> (cmd_valid && cmd_ready));
endmodule

// File: rtl/regcmd_engine.sv
module regcmd_engine
    import regcmd_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [31:0] cmd_data,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_data
);
    err_e              hdr_err;
    bus_req_t          bus_req;
    logic [WORD_W-1:0] bus_rdata;

    regcmd_hdr_check #(.NUM_REGS(NUM_REGS)) hdr_chk_i (
        .word (cmd_data),
        .code (hdr_err)
    );

    regcmd_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_data  (cmd_data),
        .hdr_err   (hdr_err),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .bus_req   (bus_req),
        .bus_rdata (bus_rdata)
    );

    regcmd_regfile #(.NUM_REGS(NUM_REGS)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .req   (bus_req),
        .rdata (bus_rdata)
    );

    // R10/R1: the cycle after reset the block is idle
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (cmd_ready && !rsp_valid));
endmodule

// File: tb/regcmd_engine_tb_top.sv
module regcmd_engine_tb_top;
    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int stall_ctr = 0;
    logic [31:0] model [NR];

    always #2 clk = ~clk;

    regcmd_engine #(.NUM_REGS(NR)) dut_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] status_of(input int op, input int code, input int n);
        return (32'(op) << 28) | (32'(code) << 24) | (32'(n) & 32'hFFF);
    endfunction

    function automatic logic [31:0] header(input int op, input int addr, input int n);
        return (32'(op) << 28) | ((32'(addr) & 32'hFFFF) << 12) | (32'(n) & 32'hFFF);
    endfunction

    function automatic logic [31:0] pay_of(input int s, input int n, input int k);
        return (32'(s * 256 + n * 16 + k) + 32'd1) * 32'h9E3779B1;
    endfunction

    task automatic send_word(input logic [31:0] w);
        cmd_valid = 1'b1;
        cmd_data  = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // R8: stalls the reply a varying number of cycles and checks it is held
    task automatic recv_word(output logic [31:0] w);
        int stall;
        rsp_ready = 1'b0;
        while (!rsp_valid) @(negedge clk);
        w = rsp_data;
        stall = stall_ctr % 4;
        stall_ctr++;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R8 held valid", 32'(rsp_valid), 32'd1);
            check("R8 held data", rsp_data, w);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic run_cmd(input int op, input int s, input int n);
        logic [31:0] w;
        logic [31:0] p;
        logic [31:0] e;
        send_word(header(op, s, n));
        recv_word(w);
        check("R7 status", w, status_of(op, 0, n));
        for (int k = 0; k < n; k++) begin
            p = pay_of(s, n, k);
            case (op)
                0: begin
                    recv_word(w);
                    check("R3 read word", w, model[s + k]);
                end
                1: begin
                    send_word(p);
                    model[s + k] = p;
                end
                default: begin
                    if (op == 2) e = model[s + k] | p;
                    else if (op == 3) e = model[s + k] & p;
                    else e = model[s + k] ^ p;
                    model[s + k] = e;
                    send_word(p);
                    recv_word(w);
                    check("R5 merge result", w, e);
                end
            endcase
        end
    endtask

    task automatic run_bad(input int op, input int s, input int n, input int code);
        logic [31:0] w;
        send_word(header(op, s, n));
        recv_word(w);
        check("R6 reject status", w, status_of(op, code, n));
        @(negedge clk);
        check("R6 back to idle", 32'({cmd_ready, rsp_valid}), 32'd2);
    endtask

    task automatic dump_all(input string req);
        logic [31:0] w;
        send_word(header(0, 0, NR));
        recv_word(w);
        check(req, w, status_of(0, 0, NR));
        for (int a = 0; a < NR; a++) begin
            recv_word(w);
            check(req, w, model[a]);
        end
    endtask

    initial begin
        for (int a = 0; a < NR; a++) model[a] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        dump_all("R1 zero after reset");

        // R4 then R3: fill whole array, read back
        run_cmd(1, 0, NR);
        dump_all("R3 full readback");

        // R2 R3 R4 R5: sweep every legal start and length, all operations
        for (int s = 0; s < NR; s++) begin
            for (int n = 1; n <= NR - s; n++) begin
                run_cmd((s + n) % 5, s, n);
            end
        end
        dump_all("R3 after sweep");

        // R5: each merge operator on a known word
        run_cmd(1, 5, 1);
        run_cmd(2, 5, 1);
        run_cmd(3, 5, 1);
        run_cmd(4, 5, 1);

        // R6: rejections, then array unchanged
        for (int op = 5; op < 16; op++) run_bad(op, 0, 1, 1);
        run_bad(7, 0, 0, 1);
        run_bad(1, 3, 0, 2);
        run_bad(0, 0, 0, 2);
        run_bad(1, NR - 1, 2, 3);
        run_bad(2, NR, 1, 3);
        run_bad(0, 0, NR + 1, 3);
        run_bad(1, 16'hFFFF, 12'hFFF, 3);
        run_bad(4, 16'hFFFF, 1, 3);
        dump_all("R6 untouched after rejects");
        run_cmd(0, NR - 1, 1);
        run_cmd(4, NR - 1, 1);

        // R10: reset in the middle of a write burst
        begin
            logic [31:0] w;
            send_word(header(1, 2, 4));
            recv_word(w);
            check("R10 status", w, status_of(1, 0, 4));
            send_word(32'hDEADBEEF);
            rst = 1'b1;
            repeat (2) @(negedge clk);
            rst = 1'b0;
            for (int a = 0; a < NR; a++) model[a] = '0;
            check("R10 cmd_ready", 32'(cmd_ready), 32'd1);
            check("R10 rsp_valid", 32'(rsp_valid), 32'd0);
            dump_all("R10 cleared");
        end

        finish_run();
    end
endmodule